// File: doc/BRIEF.md
# CSI-2 Receiver Bring-up Sequencer

This block is the control engine that takes a CSI-2 receiver controller out of reset and proves its lanes are alive before it declares a video stream active. A stream user asks for streaming with a one-cycle `req_on` pulse and releases it with `req_off`. The block keeps a count of stream users. Only the first user starts the hardware, and only the last user stops it. Requests made in between change the count and nothing else.

Start-up follows a fixed order. The block programs the lane-count value, then releases three active-low enables together: PHY shutdown, D-PHY reset and controller reset. It then waits for every configured lane and the clock lane to show stop state, which means LP-11. Next it asks the upstream sensor to start, and finally it waits for the PHY to report a high-speed clock. Each wait is bounded by a timeout counter.

Each failure unwinds only what has already been done. If the high-speed clock never arrives, the sensor is stopped before the enables drop. A sticky code records which step failed. The PHY status word arrives as a plain input, and the sensor is driven through a command/response handshake.

Top module: `csi2_bringup_seq`

## Requirements
- R1: After reset the three enables are low, `lane_count` is 0, `streaming` is 0, `err_code` is 0 and no sensor command is issued.
- R2: A start loads `lane_count` with the configured lane count minus one, one cycle before the three enables rise together; they rise in the same cycle and never differ.
- R3: After the enables rise, the start command (`sensor_cmd_vld` with `sensor_cmd_on`=1) is issued only after status bit 10 and status bits 4 up to 4+N-1 (N = configured lanes) were all 1 in the same cycle.
- R4: After a sensor response with `sensor_rsp_err`=0, the block waits for status bit 8. When bit 8 is seen, `op_done` pulses and `streaming` becomes 1.
- R5: Each wait (LP-11, sensor response, HS clock) lasts at most the timeout limit in cycles, counted from the first cycle in that wait. A condition that arrives in the last cycle of the wait still counts as success.
- R6: If the LP-11 wait times out, or the sensor answers the start with an error, or the sensor does not answer in time, the enables drop to 0 and `op_fail` pulses. No stop command is sent.
- R7: If the HS-clock wait times out, a stop command (`sensor_cmd_on`=0) is issued while the enables are still high. The enables drop only after the sensor responds or the wait times out, and then `op_fail` pulses.
- R8: A stop request at a count of 1 issues the stop command first, then drops the enables, pulses `op_done` and clears `streaming`.
- R9: A start request at a count of 1 or more, or a stop request at a count of 2 or more, changes the count by one and pulses `op_done` on the next cycle. It issues no sensor command and does not change the enables.
- R10: `req_err` pulses, and nothing else changes, in these cases: a start request with no linked sensor, no enabled channel, a lane count outside 1..MAX_LANES, or a count already at its maximum; a stop request at a count of 0; a request while a sequence is running; start and stop requested in the same cycle.
- R11: `err_code` holds 1 for an LP-11 timeout, 2 for an HS-clock timeout and 3 for a sensor start failure. It keeps this value until the next start sequence begins, which clears it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_on | input | 1 | Stream-on request pulse |
| req_off | input | 1 | Stream-off request pulse |
| cfg_lanes | input | $clog2(MAX_LANES+1) | Configured number of data lanes |
| sensor_linked | input | 1 | An upstream sensor is attached |
| chan_en | input | NCHAN | Output channel enables |
| phy_status | input | STAT_W | PHY status word (stop-state and HS clock bits) |
| sensor_rsp_vld | input | 1 | Sensor response strobe |
| sensor_rsp_err | input | 1 | Sensor response reports failure |
| lane_count | output | LCW | Lane-count register value (lanes minus one) |
| phy_shutdown_n | output | 1 | PHY shutdown release, active low |
| dphy_rst_n | output | 1 | D-PHY reset release, active low |
| ctrl_rst_n | output | 1 | Controller reset release, active low |
| sensor_cmd_vld | output | 1 | Sensor command strobe |
| sensor_cmd_on | output | 1 | Command kind: 1 start, 0 stop |
| streaming | output | 1 | At least one stream user is active |
| op_done | output | 1 | Request or sequence completed |
| op_fail | output | 1 | Start-up sequence aborted |
| req_err | output | 1 | Request refused |
| err_code | output | 2 | Sticky failure code |

## Verification
Two pairs of events can land in the same cycle.

The first pair is the LP-11 condition and the expiry of the timeout counter. The bench waits until it sees the enables rise, counts exactly to the last cycle of the wait, and only then completes the stop-state bits. It expects a normal start. A repeat run that completes the bits one cycle later must end in a failure with code 1.

The second pair is a start request and a stop request arriving in the same cycle. This must give a single refusal and leave the count, the enables and the sensor command counters unchanged. The scoreboard checks every result pulse against the queue of expected outcomes in order.

// File: rtl/csi2_seq_pkg.sv
package csi2_seq_pkg;

    // Status word bit positions decoded by the PHY side
    localparam int STOP_CLK_BIT  = 10;
    localparam int HS_CLK_BIT    = 8;
    localparam int STOP_DATA_LSB = 4;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_PROG  = 3'd1,
        S_WLP   = 3'd2,
        S_SON   = 3'd3,
        S_WSON  = 3'd4,
        S_WHS   = 3'd5,
        S_SOFF  = 3'd6,
        S_WSOFF = 3'd7
    } seq_state_e;

    typedef enum logic [1:0] {
        ERR_NONE   = 2'd0,
        ERR_LP11   = 2'd1,
        ERR_HSCLK  = 2'd2,
        ERR_SENSOR = 2'd3
    } seq_err_e;

    function automatic logic is_wait(seq_state_e s);
        return (s == S_WLP) || (s == S_WSON) || (s == S_WHS) || (s == S_WSOFF);
    endfunction

endpackage

// File: rtl/csi2_use_count.sv
module csi2_use_count #(
    parameter int USERS_MAX = 15,
    localparam int CW = $clog2(USERS_MAX + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic inc,
    input  logic dec,
    output logic is_zero,
    output logic is_one,
    output logic is_full
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (inc && !dec && !is_full) begin
            cnt_q <= cnt_q + CW'(1);
        end else if (dec && !inc && !is_zero) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign is_zero = (cnt_q == '0);
    assign is_one  = (cnt_q == CW'(1));
    assign is_full = (cnt_q == CW'(USERS_MAX));

    // R9
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(cnt_q) |-> ((cnt_q - $past(cnt_q)) == CW'(1) || ($past(cnt_q) - cnt_q) == CW'(1)));
endmodule

// File: rtl/csi2_wait_timer.sv
module csi2_wait_timer #(
    parameter int LIMIT = 16,
    localparam int TW = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic expired
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (!expired) begin
            cnt_q <= cnt_q + TW'(1);
        end
    end

    assign expired = (cnt_q == TW'(LIMIT - 1));

    // R5
    timer_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= TW'(LIMIT - 1));
endmodule

// File: rtl/csi2_seq_ctrl.sv
module csi2_seq_ctrl
    import csi2_seq_pkg::*;
#(
    parameter int MAX_LANES = 4,
    parameter int STAT_W    = 16,
    localparam int LIN_W = $clog2(MAX_LANES + 1),
    localparam int LCW   = (MAX_LANES > 1) ? $clog2(MAX_LANES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_on,
    input  logic              req_off,
    input  logic [LIN_W-1:0]  cfg_lanes,
    input  logic              src_ok,
    input  logic [STAT_W-1:0] phy_status,
    input  logic              rsp_vld,
    input  logic              rsp_err,
    input  logic              cnt_zero,
    input  logic              cnt_one,
    input  logic              cnt_full,
    input  logic              tmo,
    output logic              cnt_inc,
    output logic              cnt_dec,
    output logic              tmo_clr,
    output logic [LCW-1:0]    lane_q,
    output logic              en_q,
    output logic              cmd_vld,
    output logic              cmd_on,
    output logic              done_q,
    output logic              fail_q,
    output logic              rej_q,
    output logic [1:0]        err_q
);
    seq_state_e        st_q, st_d;
    logic [STAT_W-1:0] mask_q, mask_d;
    logic              abort_q, abort_d;
    logic              en_set, en_clr, lanes_ld, err_clr, err_set;
    seq_err_e          err_val;
    logic              done_d, fail_d, rej_d;
    logic              lanes_ok, lp_ok, hs_ok, any_req;

    // one stop-state bit per configured data lane plus the clock lane
    always_comb begin
        mask_d = '0;
        mask_d[STOP_CLK_BIT] = 1'b1;
        for (int i = 0; i < MAX_LANES; i++) begin
            if (i < int'(cfg_lanes)) mask_d[STOP_DATA_LSB + i] = 1'b1;
        end
    end

    assign lanes_ok = (cfg_lanes != '0) && (int'(cfg_lanes) <= MAX_LANES);
    assign lp_ok    = ((phy_status & mask_q) == mask_q);
    assign hs_ok    = phy_status[HS_CLK_BIT];
    assign any_req  = req_on | req_off;

    always_comb begin
        st_d     = st_q;
        abort_d  = abort_q;
        en_set   = 1'b0;
        en_clr   = 1'b0;
        lanes_ld = 1'b0;
        err_clr  = 1'b0;
        err_set  = 1'b0;
        err_val  = ERR_NONE;
        done_d   = 1'b0;
        fail_d   = 1'b0;
        rej_d    = 1'b0;
        cnt_inc  = 1'b0;
        cnt_dec  = 1'b0;
        if (any_req && st_q != S_IDLE) rej_d = 1'b1;
        case (st_q)
            S_IDLE: begin
                if (req_on && req_off) begin
                    rej_d = 1'b1;
                end else if (req_on) begin
                    if (!src_ok || !lanes_ok || cnt_full) begin
                        rej_d = 1'b1;
                    end else if (cnt_zero) begin
                        st_d     = S_PROG;
                        lanes_ld = 1'b1;
                        err_clr  = 1'b1;
                    end else begin
                        cnt_inc = 1'b1;
                        done_d  = 1'b1;
                    end
                end else if (req_off) begin
                    if (cnt_zero) begin
                        rej_d = 1'b1;
                    end else if (cnt_one) begin
                        st_d    = S_SOFF;
                        abort_d = 1'b0;
                    end else begin
                        cnt_dec = 1'b1;
                        done_d  = 1'b1;
                    end
                end
            end
            S_PROG: begin
                en_set = 1'b1;
                st_d   = S_WLP;
            end
            S_WLP: begin
                if (lp_ok) begin
                    st_d = S_SON;
                end else if (tmo) begin
                    err_set = 1'b1;
                    err_val = ERR_LP11;
                    en_clr  = 1'b1;
                    fail_d  = 1'b1;
                    st_d    = S_IDLE;
                end
            end
            S_SON: st_d = S_WSON;
            S_WSON: begin
                if (rsp_vld && !rsp_err) begin
                    st_d = S_WHS;
                end else if (rsp_vld || tmo) begin
                    err_set = 1'b1;
                    err_val = ERR_SENSOR;
                    en_clr  = 1'b1;
                    fail_d  = 1'b1;
                    st_d    = S_IDLE;
                end
            end
            S_WHS: begin
                if (hs_ok) begin
                    cnt_inc = 1'b1;
                    done_d  = 1'b1;
                    st_d    = S_IDLE;
                end else if (tmo) begin
                    err_set = 1'b1;
                    err_val = ERR_HSCLK;
                    abort_d = 1'b1;
                    st_d    = S_SOFF;
                end
            end
            S_SOFF: st_d = S_WSOFF;
            S_WSOFF: begin
                if (rsp_vld || tmo) begin
                    en_clr = 1'b1;
                    st_d   = S_IDLE;
                    if (abort_q) begin
                        fail_d = 1'b1;
                    end else begin
                        done_d  = 1'b1;
                        cnt_dec = 1'b1;
                    end
                end
            end
            default: st_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= S_IDLE;
            abort_q <= 1'b0;
            mask_q  <= '0;
            lane_q  <= '0;
            en_q    <= 1'b0;
            err_q   <= ERR_NONE;
            done_q  <= 1'b0;
            fail_q  <= 1'b0;
            rej_q   <= 1'b0;
        end else begin
            st_q    <= st_d;
            abort_q <= abort_d;
            done_q  <= done_d;
            fail_q  <= fail_d;
            rej_q   <= rej_d;
            if (lanes_ld) begin
                mask_q <= mask_d;
                lane_q <= LCW'(cfg_lanes - LIN_W'(1));
            end
            if (en_set) en_q <= 1'b1;
            else if (en_clr) en_q <= 1'b0;
            if (err_clr) err_q <= ERR_NONE;
            else if (err_set) err_q <= err_val;
        end
    end

    assign cmd_vld = (st_q == S_SON) || (st_q == S_SOFF);
    assign cmd_on  = (st_q == S_SON);
    assign tmo_clr = !is_wait(st_q) || (st_d != st_q);

    // R2
    lanes_before_release_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(en_q) |-> $stable(lane_q));
    // R3
    lp11_before_start_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_vld && cmd_on) |-> $past((phy_status & mask_q) == mask_q));
    // R7
    stop_cmd_enabled_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_vld |-> en_q);
    // R6
    single_outcome_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done_q, fail_q}));
endmodule

// File: rtl/csi2_bringup_seq.sv
module csi2_bringup_seq
    import csi2_seq_pkg::*;
#(
    parameter int MAX_LANES       = 4,
    parameter int NCHAN           = 4,
    parameter int STAT_W          = 16,
    parameter int USERS_MAX       = 15,
    parameter int TIMEOUT_CYC     = 50_000_000,
    parameter int SIM_TIMEOUT_CYC = 64,
    parameter bit SHORT_SIM       = 1'b0,
    localparam int LIN_W = $clog2(MAX_LANES + 1),
    localparam int LCW   = (MAX_LANES > 1) ? $clog2(MAX_LANES) : 1,
    localparam int LIMIT = SHORT_SIM ? SIM_TIMEOUT_CYC : TIMEOUT_CYC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_on,
    input  logic              req_off,
    input  logic [LIN_W-1:0]  cfg_lanes,
    input  logic              sensor_linked,
    input  logic [NCHAN-1:0]  chan_en,
    input  logic [STAT_W-1:0] phy_status,
    input  logic              sensor_rsp_vld,
    input  logic              sensor_rsp_err,
    output logic [LCW-1:0]    lane_count,
    output logic              phy_shutdown_n,
    output logic              dphy_rst_n,
    output logic              ctrl_rst_n,
    output logic              sensor_cmd_vld,
    output logic              sensor_cmd_on,
    output logic              streaming,
    output logic              op_done,
    output logic              op_fail,
    output logic              req_err,
    output logic [1:0]        err_code
);
    logic cnt_inc, cnt_dec, cnt_zero, cnt_one, cnt_full;
    logic tmo_clr, tmo;
    logic en;

    csi2_use_count #(.USERS_MAX(USERS_MAX)) u_count (
        .clk     (clk),
        .rst     (rst),
        .inc     (cnt_inc),
        .dec     (cnt_dec),
        .is_zero (cnt_zero),
        .is_one  (cnt_one),
        .is_full (cnt_full)
    );

    csi2_wait_timer #(.LIMIT(LIMIT)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clr     (tmo_clr),
        .expired (tmo)
    );

    csi2_seq_ctrl #(.MAX_LANES(MAX_LANES), .STAT_W(STAT_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req_on     (req_on),
        .req_off    (req_off),
        .cfg_lanes  (cfg_lanes),
        .src_ok     (sensor_linked && (|chan_en)),
        .phy_status (phy_status),
        .rsp_vld    (sensor_rsp_vld),
        .rsp_err    (sensor_rsp_err),
        .cnt_zero   (cnt_zero),
        .cnt_one    (cnt_one),
        .cnt_full   (cnt_full),
        .tmo        (tmo),
        .cnt_inc    (cnt_inc),
        .cnt_dec    (cnt_dec),
        .tmo_clr    (tmo_clr),
        .lane_q     (lane_count),
        .en_q       (en),
        .cmd_vld    (sensor_cmd_vld),
        .cmd_on     (sensor_cmd_on),
        .done_q     (op_done),
        .fail_q     (op_fail),
        .rej_q      (req_err),
        .err_q      (err_code)
    );

    assign phy_shutdown_n = en;
    assign dphy_rst_n     = en;
    assign ctrl_rst_n     = en;
    assign streaming      = !cnt_zero;

    // R4
    stream_needs_hs_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(streaming) |-> $past(phy_status[HS_CLK_BIT]));
endmodule

// File: tb/csi2_bringup_seq_bench.sv
module csi2_bringup_seq_bench;
    localparam int TMO = 16;
    localparam int RSP_LAT = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_on = 1'b0, req_off = 1'b0;
    logic [2:0] cfg_lanes = 3'd2;
    logic sensor_linked = 1'b1;
    logic [3:0] chan_en = 4'b0001;
    logic [15:0] phy_status = '0;
    logic sensor_rsp_vld = 1'b0, sensor_rsp_err = 1'b0;
    logic [1:0] lane_count;
    logic phy_shutdown_n, dphy_rst_n, ctrl_rst_n;
    logic sensor_cmd_vld, sensor_cmd_on, streaming;
    logic op_done, op_fail, req_err;
    logic [1:0] err_code;

    always #4 clk = ~clk;

    csi2_bringup_seq #(
        .MAX_LANES(4), .NCHAN(4), .STAT_W(16), .USERS_MAX(3),
        .SIM_TIMEOUT_CYC(TMO), .SHORT_SIM(1'b1)
    ) u_csi2_bringup_seq (
        .clk(clk), .rst(rst), .req_on(req_on), .req_off(req_off),
        .cfg_lanes(cfg_lanes), .sensor_linked(sensor_linked), .chan_en(chan_en),
        .phy_status(phy_status), .sensor_rsp_vld(sensor_rsp_vld),
        .sensor_rsp_err(sensor_rsp_err), .lane_count(lane_count),
        .phy_shutdown_n(phy_shutdown_n), .dphy_rst_n(dphy_rst_n),
        .ctrl_rst_n(ctrl_rst_n), .sensor_cmd_vld(sensor_cmd_vld),
        .sensor_cmd_on(sensor_cmd_on), .streaming(streaming),
        .op_done(op_done), .op_fail(op_fail), .req_err(req_err),
        .err_code(err_code)
    );

    int checks = 0;
    int fails = 0;
    int n_on = 0, n_off = 0;
    int en_at_off = -1;
    logic sens_err_next = 1'b0;

    typedef struct { int kind; int err; string tag; } ev_t;
    ev_t q[$];
    localparam int EV_DONE = 1, EV_FAIL = 2, EV_REJ = 3;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic expect_ev(input int kind, input int err, input string tag);
        ev_t e;
        e.kind = kind; e.err = err; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic pop_cmp(input int kind);
        ev_t e;
        if (q.size() == 0) begin
            chk(1'b0, "unexpected result pulse", kind, 0);
        end else begin
            e = q.pop_front();
            chk(kind == e.kind, e.tag, kind, e.kind);
            if (kind == EV_FAIL) chk(int'(err_code) == e.err, {e.tag, " err_code"}, int'(err_code), e.err);
        end
    endtask

    // monitor: result pulses against the expected queue
    always @(negedge clk) begin
        if (!rst) begin
            if (req_err) pop_cmp(EV_REJ);
            if (op_fail) pop_cmp(EV_FAIL);
            if (op_done) pop_cmp(EV_DONE);
            if (phy_shutdown_n != dphy_rst_n || dphy_rst_n != ctrl_rst_n)
                chk(1'b0, "R2 enables differ", int'(dphy_rst_n), int'(phy_shutdown_n));
        end
    end

    // sensor model
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && sensor_cmd_vld) begin
                logic was_on;
                was_on = sensor_cmd_on;
                if (was_on) n_on++;
                else begin
                    n_off++;
                    en_at_off = int'(phy_shutdown_n);
                end
                repeat (RSP_LAT) @(negedge clk);
                sensor_rsp_vld = 1'b1;
                sensor_rsp_err = was_on ? sens_err_next : 1'b0;
                @(negedge clk);
                sensor_rsp_vld = 1'b0;
                sensor_rsp_err = 1'b0;
                if (was_on) sens_err_next = 1'b0;
            end
        end
    end

    task automatic request(input bit on, input bit off);
        @(negedge clk);
        req_on = on; req_off = off;
        @(negedge clk);
        req_on = 1'b0; req_off = 1'b0;
    endtask

    task automatic drain(input string tag);
        int n = 0;
        while (q.size() != 0 && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk(q.size() == 0, {tag, " outstanding results"}, q.size(), 0);
        q.delete();
        repeat (3) @(negedge clk);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    function automatic logic [15:0] full_status(input int lanes, input bit hs);
        logic [15:0] s = '0;
        s[10] = 1'b1;
        s[8] = hs;
        for (int i = 0; i < lanes; i++) s[4 + i] = 1'b1;
        return s;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int on0, off0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(phy_shutdown_n == 0 && dphy_rst_n == 0 && ctrl_rst_n == 0, "R1 enables", int'(phy_shutdown_n), 0);
        chk(lane_count == 0 && streaming == 0, "R1 lane_count/streaming", int'(lane_count), 0);
        chk(err_code == 0 && sensor_cmd_vld == 0, "R1 err/cmd", int'(err_code), 0);

        // R2 R3 R4: normal start, 2 lanes
        cfg_lanes = 3'd2;
        phy_status = full_status(2, 1'b1);
        expect_ev(EV_DONE, 0, "R4 start done");
        request(1, 0);
        drain("R4");
        chk(phy_shutdown_n && dphy_rst_n && ctrl_rst_n, "R2 enables released", int'(phy_shutdown_n), 1);
        chk(lane_count == 2'd1, "R2 lane_count", int'(lane_count), 1);
        chk(n_on == 1, "R3 one start command", n_on, 1);
        chk(streaming == 1, "R4 streaming", int'(streaming), 1);
        chk(err_code == 0, "R11 no error", int'(err_code), 0);

        // R9: count-only adjustments
        expect_ev(EV_DONE, 0, "R9 second on");
        request(1, 0);
        drain("R9a");
        chk(n_on == 1 && phy_shutdown_n == 1, "R9 no command on inc", n_on, 1);
        expect_ev(EV_DONE, 0, "R9 first off");
        request(0, 1);
        drain("R9b");
        chk(n_off == 0 && phy_shutdown_n == 1 && streaming == 1, "R9 no command on dec", n_off, 0);

        // R8: last user stops
        expect_ev(EV_DONE, 0, "R8 stop done");
        request(0, 1);
        drain("R8");
        chk(n_off == 1, "R8 stop command", n_off, 1);
        chk(en_at_off == 1, "R8 stop before resets", en_at_off, 1);
        chk(phy_shutdown_n == 0 && streaming == 0, "R8 resets reasserted", int'(phy_shutdown_n), 0);

        // R10: refusals
        on0 = n_on;
        expect_ev(EV_REJ, 0, "R10 off at zero");
        request(0, 1);
        drain("R10a");
        sensor_linked = 1'b0;
        expect_ev(EV_REJ, 0, "R10 no sensor");
        request(1, 0);
        drain("R10b");
        sensor_linked = 1'b1;
        chan_en = 4'b0000;
        expect_ev(EV_REJ, 0, "R10 no channel");
        request(1, 0);
        drain("R10c");
        chan_en = 4'b0100;
        cfg_lanes = 3'd5;
        expect_ev(EV_REJ, 0, "R10 lanes too many");
        request(1, 0);
        drain("R10d");
        cfg_lanes = 3'd0;
        expect_ev(EV_REJ, 0, "R10 zero lanes");
        request(1, 0);
        drain("R10e");
        cfg_lanes = 3'd2;
        expect_ev(EV_REJ, 0, "R10 on+off same cycle");
        request(1, 1);
        drain("R10f");
        chk(n_on == on0 && phy_shutdown_n == 0 && streaming == 0, "R10 nothing changed", n_on, on0);

        // R6 R11: LP-11 timeout, lane 3 missing
        cfg_lanes = 3'd4;
        phy_status = full_status(3, 1'b1);
        on0 = n_on; off0 = n_off;
        expect_ev(EV_FAIL, 1, "R6 LP-11 timeout");
        request(1, 0);
        drain("R6a");
        chk(n_on == on0 && n_off == off0, "R6 no sensor command", n_on, on0);
        chk(phy_shutdown_n == 0 && streaming == 0, "R6 resets reasserted", int'(phy_shutdown_n), 0);
        chk(err_code == 2'd1, "R11 LP-11 code sticky", int'(err_code), 1);

        // R5: condition in last cycle of the wait wins
        expect_ev(EV_DONE, 0, "R5 last-cycle success");
        request(1, 0);
        while (!phy_shutdown_n) @(negedge clk);
        repeat (TMO - 1) @(negedge clk);
        phy_status = full_status(4, 1'b1);
        drain("R5a");
        chk(streaming == 1, "R5 streaming after last-cycle LP-11", int'(streaming), 1);
        chk(err_code == 0, "R11 cleared by new start", int'(err_code), 0);
        expect_ev(EV_DONE, 0, "R5 stop");
        request(0, 1);
        drain("R5b");

        // R5: one cycle late times out
        phy_status = full_status(3, 1'b1);
        expect_ev(EV_FAIL, 1, "R5 one cycle late");
        request(1, 0);
        while (!phy_shutdown_n) @(negedge clk);
        repeat (TMO) @(negedge clk);
        phy_status = full_status(4, 1'b1);
        drain("R5c");
        chk(streaming == 0, "R5 not streaming after late LP-11", int'(streaming), 0);

        // R6: sensor start error
        off0 = n_off;
        sens_err_next = 1'b1;
        expect_ev(EV_FAIL, 3, "R6 sensor error");
        request(1, 0);
        drain("R6b");
        chk(n_off == off0 && phy_shutdown_n == 0, "R6 no stop after sensor error", n_off, off0);
        chk(err_code == 2'd3, "R11 sensor code", int'(err_code), 3);

        // R7: HS clock timeout
        phy_status = full_status(4, 1'b0);
        en_at_off = -1;
        expect_ev(EV_FAIL, 2, "R7 HS timeout");
        request(1, 0);
        drain("R7");
        chk(n_off == off0 + 1, "R7 stop command issued", n_off, off0 + 1);
        chk(en_at_off == 1, "R7 stop before resets", en_at_off, 1);
        chk(phy_shutdown_n == 0 && streaming == 0, "R7 resets reasserted", int'(phy_shutdown_n), 0);
        chk(err_code == 2'd2, "R11 HS code", int'(err_code), 2);

        // R10: request while busy
        phy_status = full_status(4, 1'b1);
        expect_ev(EV_REJ, 0, "R10 busy refusal");
        expect_ev(EV_DONE, 0, "R10 start after busy");
        @(negedge clk);
        req_on = 1'b1;
        @(negedge clk);
        @(negedge clk);
        req_on = 1'b0;
        drain("R10g");
        // R10: count full (max 3)
        expect_ev(EV_DONE, 0, "R9 inc to 2");
        request(1, 0);
        expect_ev(EV_DONE, 0, "R9 inc to 3");
        request(1, 0);
        expect_ev(EV_REJ, 0, "R10 count full");
        request(1, 0);
        drain("R10h");
        expect_ev(EV_DONE, 0, "R9 dec");
        request(0, 1);
        expect_ev(EV_DONE, 0, "R9 dec");
        request(0, 1);
        expect_ev(EV_DONE, 0, "R8 final stop");
        request(0, 1);
        drain("R8b");
        chk(streaming == 0 && phy_shutdown_n == 0, "R8 idle at end", int'(streaming), 0);

        summary();
        $finish;
    end
endmodule